// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an on-chip request/acknowledge port and an external asynchronous static RAM of 262,144 bytes. A requester raises `req` with a direction, an 18-bit word address and, for a write, one byte of data. It holds those inputs until `ack` appears. The controller then produces the chip-enable, output-enable and write-enable strobes for the RAM, each held for a whole number of system-clock cycles. The RAM has one active-low and one active-high chip enable.

Phase lengths are fixed at elaboration from the clock period and a speed-grade parameter. The fast grade uses 55 ns access, 25 ns output-enable-to-valid, 40 ns write pulse, 50 ns address-to-end-of-write and 25 ns data setup. The slow grade uses 70, 35, 50, 60 and 30 ns. Both grades use a 25 ns bus release, and the minimum cycle equals the access time. Each count is the ceiling of the required nanoseconds over the period, and never less than one cycle.

The write data bus is split into an output value, an output enable and an input. The controller turns on its drivers only inside a write, after the RAM has had time to let go of the bus.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the RAM is deselected: `ram_ce_n`=1, `ram_ce`=0, `ram_oe_n`=1 and `ram_we_n`=1. In the same cycles `ram_dq_oe`=0 and `ack`=0.
- R2: Whenever no transfer is in progress, the controller holds the RAM deselected with both `ram_oe_n` and `ram_we_n` high, and it does not drive the bus.
- R3: A read selects the chip (`ram_ce_n`=0, `ram_ce`=1) with `ram_oe_n`=0, `ram_we_n`=1 and the bus released. It holds this for exactly ceil(max(access, output-enable-to-valid)/period) cycles. At 10 ns on the fast grade this is 6 cycles.
- R4: Read data is sampled at the clock edge that ends the read window. It appears on `rdata` together with a one-cycle `ack` in the first deselected cycle.
- R5: A write keeps the chip selected, holds `ram_oe_n` high throughout, and pulls `ram_we_n` low for a lead-in phase followed by a data phase. The low time is at least the write pulse and at least the address-to-end-of-write time. The whole selected time is at least the cycle time. At 10 ns on the fast grade this is 3 lead-in cycles plus 3 data cycles.
- R6: `ram_dq_oe` is high only during a write and never while `ram_oe_n` is low. It first rises ceil(25 ns/period) cycles after the RAM stops driving (3 cycles at 10 ns).
- R7: Write data is driven unchanged for at least ceil(setup/period) cycles before `ram_we_n` rises. It stays driven and unchanged for the one cycle after the rise, with the chip still selected, and is released when the chip is deselected.
- R8: A write ends with a one-cycle `ack` in the first deselected cycle. A request is taken only from the idle state and never in the cycle in which `ack` is high, so a request still held in that cycle does not start a second transfer.
- R9: The address, and for a write the data, are captured when the request is taken. `ram_addr` and `ram_dq_o` then stay unchanged while the chip is selected, whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Transfer request, held until `ack` |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with a read `ack` |
| ram_addr | output | 18 | RAM address bus |
| ram_ce_n | output | 1 | Active-low chip enable |
| ram_ce | output | 1 | Active-high chip enable |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write enable |
| ram_dq_o | output | 8 | Data bus value driven by the controller |
| ram_dq_oe | output | 1 | Data bus driver enable |
| ram_dq_i | input | 8 | Data bus value seen from the RAM |

## Verification
The RAM model in the bench returns a garbage byte until the access and output-enable times have elapsed. A read window that is one cycle too short therefore shows up as wrong read data rather than a strobe mismatch. A write directly after a read checks the bus turnaround: a controller that drives early would overlap the RAM's release time, and the model's contention check would flag it. A request held through the acknowledge cycle must not start a duplicate transfer. The request inputs are scrambled right after acceptance, so a design that forwards them instead of its latched copies would corrupt the address or the data. At each rising edge of the write enable, the model measures the pulse width and the data setup time, and it stores only what it saw at that moment.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WLEAD,
    ST_WDATA,
    ST_WEND
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic ce;
    logic oe_n;
    logic we_n;
    logic drive;
  } pins_t;

  typedef enum int {
    SP_ACCESS,
    SP_OE_VALID,
    SP_PULSE,
    SP_ADDR_END,
    SP_DATA_SETUP,
    SP_BUS_RELEASE,
    SP_CYCLE
  } spec_e;

  // Minimum nanoseconds for one timing item of the chosen grade
  function automatic int spec_ns(bit slow, spec_e item);
    case (item)
      SP_ACCESS:      return slow ? 70 : 55;
      SP_OE_VALID:    return slow ? 35 : 25;
      SP_PULSE:       return slow ? 50 : 40;
      SP_ADDR_END:    return slow ? 60 : 50;
      SP_DATA_SETUP:  return slow ? 30 : 25;
      SP_BUS_RELEASE: return 25;
      SP_CYCLE:       return slow ? 70 : 55;
      default:        return 0;
    endcase
  endfunction

  function automatic int ns_to_cycles(int ns, int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Pin levels for each phase
  function automatic pins_t phase_pins(phase_e p);
    case (p)
      ST_READ:  return pins_t'{ce_n: 1'b0, ce: 1'b1, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
      ST_WLEAD: return pins_t'{ce_n: 1'b0, ce: 1'b1, oe_n: 1'b1, we_n: 1'b0, drive: 1'b0};
      ST_WDATA: return pins_t'{ce_n: 1'b0, ce: 1'b1, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
      ST_WEND:  return pins_t'{ce_n: 1'b0, ce: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
      default:  return pins_t'{ce_n: 1'b1, ce: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
    endcase
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_len - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int RD_CYC = 6,
  parameter int HZ_CYC = 3,
  parameter int WD_CYC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_wr,
  input  logic             phase_last,
  output phase_e           phase,
  output phase_e           phase_nxt,
  output logic             load,
  output logic [CNT_W-1:0] load_len,
  output logic             rd_done,
  output logic             wr_done
);

  always_comb begin
    phase_nxt = phase;
    load      = 1'b0;
    load_len  = '0;
    rd_done   = 1'b0;
    wr_done   = 1'b0;
    case (phase)
      ST_IDLE: begin
        if (start) begin
          load = 1'b1;
          if (start_wr) begin
            phase_nxt = ST_WLEAD;
            load_len  = CNT_W'(HZ_CYC);
          end else begin
            phase_nxt = ST_READ;
            load_len  = CNT_W'(RD_CYC);
          end
        end
      end
      ST_READ: begin
        if (phase_last) begin
          phase_nxt = ST_IDLE;
          rd_done   = 1'b1;
        end
      end
      ST_WLEAD: begin
        if (phase_last) begin
          phase_nxt = ST_WDATA;
          load      = 1'b1;
          load_len  = CNT_W'(WD_CYC);
        end
      end
      ST_WDATA: begin
        if (phase_last) phase_nxt = ST_WEND;
      end
      ST_WEND: begin
        phase_nxt = ST_IDLE;
        wr_done   = 1'b1;
      end
      default: phase_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= ST_IDLE;
    else     phase <= phase_nxt;
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter bit SLOW_GRADE    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_ce,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_i
);

  localparam int AA_CYC = ns_to_cycles(spec_ns(SLOW_GRADE, SP_ACCESS), CLK_PERIOD_NS);
  localparam int OE_CYC = ns_to_cycles(spec_ns(SLOW_GRADE, SP_OE_VALID), CLK_PERIOD_NS);
  localparam int WP_CYC = ns_to_cycles(spec_ns(SLOW_GRADE, SP_PULSE), CLK_PERIOD_NS);
  localparam int AW_CYC = ns_to_cycles(spec_ns(SLOW_GRADE, SP_ADDR_END), CLK_PERIOD_NS);
  localparam int DW_CYC = ns_to_cycles(spec_ns(SLOW_GRADE, SP_DATA_SETUP), CLK_PERIOD_NS);
  localparam int RC_CYC = ns_to_cycles(spec_ns(SLOW_GRADE, SP_CYCLE), CLK_PERIOD_NS);
  localparam int HZ_CYC = ns_to_cycles(spec_ns(SLOW_GRADE, SP_BUS_RELEASE), CLK_PERIOD_NS);
  localparam int RD_CYC = max2(max2(AA_CYC, OE_CYC), RC_CYC);
  // Data phase: covers setup, and with the lead-in the pulse, address and cycle times
  localparam int WD_CYC = max2(max2(DW_CYC, WP_CYC - HZ_CYC),
                               max2(AW_CYC - HZ_CYC, max2(RC_CYC - HZ_CYC - 1, 1)));
  localparam int CNT_W  = $clog2(max2(RD_CYC, max2(HZ_CYC, WD_CYC)) + 1);

  phase_e           phase;
  phase_e           phase_nxt;
  logic             accept;
  logic             load;
  logic [CNT_W-1:0] load_len;
  logic             phase_last;
  logic             rd_done;
  logic             wr_done;
  pins_t            pins_q;
  logic             ack_q;
  logic [DATA_W-1:0] rdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  // A new transfer starts only from idle, and not in the acknowledge cycle
  assign accept = (phase == ST_IDLE) && req && !ack_q;

  asram_seq #(
    .CNT_W (CNT_W),
    .RD_CYC(RD_CYC),
    .HZ_CYC(HZ_CYC),
    .WD_CYC(WD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .start_wr  (req_wr),
    .phase_last(phase_last),
    .phase     (phase),
    .phase_nxt (phase_nxt),
    .load      (load),
    .load_len  (load_len),
    .rd_done   (rd_done),
    .wr_done   (wr_done)
  );

  asram_phase_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_len(load_len),
    .last    (phase_last)
  );

  // Strobes come straight from flops so the RAM pins never see decode glitches
  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q  <= phase_pins(ST_IDLE);
      ack_q   <= 1'b0;
      rdata_q <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      pins_q <= phase_pins(phase_nxt);
      ack_q  <= rd_done | wr_done;
      if (rd_done) rdata_q <= ram_dq_i;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  assign ack       = ack_q;
  assign rdata     = rdata_q;
  assign ram_addr  = addr_q;
  assign ram_ce_n  = pins_q.ce_n;
  assign ram_ce    = pins_q.ce;
  assign ram_oe_n  = pins_q.oe_n;
  assign ram_we_n  = pins_q.we_n;
  assign ram_dq_oe = pins_q.drive;
  assign ram_dq_o  = wdata_q;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ack,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_ce_n,
  input logic              ram_ce,
  input logic              ram_oe_n,
  input logic              ram_we_n,
  input logic [DATA_W-1:0] ram_dq_o,
  input logic              ram_dq_oe,
  input logic              accept,
  input logic              rd_done
);

  AST_RESET_PARKED: assert property (@(posedge clk)
    rst |=> (ram_ce_n && !ram_ce && ram_oe_n && ram_we_n && !ram_dq_oe && !ack)); // R1

  AST_NO_OE_WE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(!ram_oe_n && !ram_we_n)); // R5

  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !ram_oe_n |-> !ram_dq_oe); // R6

  AST_DRIVE_AFTER_WE_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_dq_oe) |-> (!ram_we_n && $past(!ram_we_n))); // R6

  AST_DRIVE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    ram_dq_oe |-> (!ram_ce_n && ram_ce)); // R7

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (ram_dq_oe && $past(ram_dq_oe)) |-> $stable(ram_dq_o)); // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!ram_ce_n && $past(!ram_ce_n)) |-> $stable(ram_addr)); // R9

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R8

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (rst)
    accept |-> (ram_ce_n && !ack)); // R8

  AST_READ_DONE_OE: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> (!ram_oe_n && ram_we_n)); // R4

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ack      (ack),
  .ram_addr (ram_addr),
  .ram_ce_n (ram_ce_n),
  .ram_ce   (ram_ce),
  .ram_oe_n (ram_oe_n),
  .ram_we_n (ram_we_n),
  .ram_dq_o (ram_dq_o),
  .ram_dq_oe(ram_dq_oe),
  .accept   (accept),
  .rd_done  (rd_done)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int DW = 8;
  // Fast-grade limits in ns
  localparam int NS_ACCESS   = 55;
  localparam int NS_OE       = 25;
  localparam int NS_PULSE    = 40;
  localparam int NS_ADDR_END = 50;
  localparam int NS_SETUP    = 25;
  localparam int NS_RELEASE  = 25;
  localparam int NS_CYCLE    = 55;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] dq_to_dut = 8'h5A;
  wire           ack;
  wire  [DW-1:0] rdata;
  wire  [AW-1:0] ram_addr;
  wire           ram_ce_n, ram_ce, ram_oe_n, ram_we_n;
  wire  [DW-1:0] ram_dq_o;
  wire           ram_dq_oe;

  asram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(CLK_PERIOD), .SLOW_GRADE(1'b0)
  ) u_dut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_ce(ram_ce), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_dq_i(dq_to_dut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    bit         ce_n, ce, oe_n, we_n, drv, ack;
    bit         chk_dout;
    logic [7:0] dout;
    bit         chk_rdata;
    logic [7:0] rdata;
    string      tag;
  } exp_t;

  exp_t          expq[$];
  logic [AW-1:0] exp_addr = '0;
  string         idle_tag = "R1";
  int            checks = 0;
  int            errors = 0;
  int            n_read, n_lead, n_data;
  logic [7:0]    golden[int];
  logic [7:0]    ram_mem[int];
  int            rd_cyc = 0, rel_cyc = 100, we_low = 0, stable = 0;
  bit            prev_we_low = 0, prev_drv = 0;
  logic [7:0]    prev_dout = '0;

  function automatic int min_cycles(int ns);
    int n = 1;
    while (n * CLK_PERIOD < ns) n++;
    return n;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic exp_t mk(bit ce_n, bit ce, bit oe_n, bit we_n, bit drv, string tag);
    exp_t e;
    e.ce_n = ce_n; e.ce = ce; e.oe_n = oe_n; e.we_n = we_n; e.drv = drv;
    e.ack = 0; e.chk_dout = 0; e.dout = '0; e.chk_rdata = 0; e.rdata = '0; e.tag = tag;
    return e;
  endfunction

  // One clock: compare against the expected cycle, then advance the RAM model
  task automatic step();
    exp_t e;
    bit   sel, out_en;
    @(negedge clk);
    if (expq.size() > 0) e = expq.pop_front();
    else                 e = mk(1, 0, 1, 1, 0, idle_tag);
    check({ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_dq_oe} == {e.ce_n, e.ce, e.oe_n, e.we_n, e.drv},
          e.tag, "strobes ce_n,ce,oe_n,we_n,drive",
          {ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_dq_oe}, {e.ce_n, e.ce, e.oe_n, e.we_n, e.drv});
    check(ack == e.ack, e.tag, "ack", ack, e.ack);
    sel = !ram_ce_n && ram_ce;
    if (sel) check(ram_addr == exp_addr, "R9", "address held", ram_addr, exp_addr);
    if (e.chk_dout) check(ram_dq_o == e.dout, "R7", "write data held", ram_dq_o, e.dout);
    if (e.chk_rdata) check(rdata == e.rdata, "R4", "read data", rdata, e.rdata);

    out_en = sel && !ram_oe_n && ram_we_n;
    if (out_en) begin rd_cyc++; rel_cyc = 0; end
    else begin rd_cyc = 0; rel_cyc++; end
    if (ram_dq_oe)
      check(!out_en && (rel_cyc - 1) * CLK_PERIOD >= NS_RELEASE, "R6",
            "cycles since RAM released bus", rel_cyc - 1, min_cycles(NS_RELEASE));

    if (sel && !ram_we_n) begin
      we_low++;
      if (ram_dq_oe && prev_drv && ram_dq_o == prev_dout) stable++;
      else if (ram_dq_oe) stable = 1;
      else stable = 0;
    end
    if (prev_we_low && sel && ram_we_n) begin
      check(we_low * CLK_PERIOD >= NS_PULSE, "R5", "write pulse cycles", we_low, min_cycles(NS_PULSE));
      check(we_low * CLK_PERIOD >= NS_ADDR_END, "R5", "address to end cycles", we_low, min_cycles(NS_ADDR_END));
      check(stable * CLK_PERIOD >= NS_SETUP, "R7", "data setup cycles", stable, min_cycles(NS_SETUP));
      check(ram_dq_oe, "R7", "data hold after write", ram_dq_oe, 1);
      ram_mem[int'(ram_addr)] = ram_dq_o;
      we_low = 0;
      stable = 0;
    end
    prev_we_low = sel && !ram_we_n;
    prev_drv    = ram_dq_oe;
    prev_dout   = ram_dq_o;

    if (out_en) begin
      if (rd_cyc * CLK_PERIOD >= NS_ACCESS && rd_cyc * CLK_PERIOD >= NS_OE)
        dq_to_dut = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 8'h00;
      else
        dq_to_dut = 8'hEE;
    end else begin
      dq_to_dut = 8'h5A;
    end
  endtask

  task automatic transfer(bit wr, logic [AW-1:0] a, logic [7:0] d, bit scramble, bit linger);
    exp_t e;
    int   n;
    step();
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; exp_addr = a;
    if (wr) begin
      golden[int'(a)] = d;
      for (int i = 0; i < n_lead; i++) expq.push_back(mk(0, 1, 1, 0, 0, "R5"));
      for (int i = 0; i < n_data; i++) begin
        e = mk(0, 1, 1, 0, 1, "R7"); e.chk_dout = 1; e.dout = d; expq.push_back(e);
      end
      e = mk(0, 1, 1, 1, 1, "R7"); e.chk_dout = 1; e.dout = d; expq.push_back(e);
      e = mk(1, 0, 1, 1, 0, "R8"); e.ack = 1; expq.push_back(e);
    end else begin
      for (int i = 0; i < n_read; i++) expq.push_back(mk(0, 1, 0, 1, 0, "R3"));
      e = mk(1, 0, 1, 1, 0, "R4"); e.ack = 1; e.chk_rdata = 1;
      e.rdata = golden.exists(int'(a)) ? golden[int'(a)] : 8'h00;
      expq.push_back(e);
    end
    n = expq.size();
    for (int i = 0; i < n; i++) begin
      step();
      if (scramble && i == 0) begin req_addr = ~a; req_wdata = ~d; end // R9
    end
    if (linger) begin
      expq.push_back(mk(1, 0, 1, 1, 0, "R8")); // held request must not restart
      step();
    end
    req = 1'b0;
  endtask

  initial begin
    n_read = min_cycles(NS_ACCESS);
    if (min_cycles(NS_OE) > n_read) n_read = min_cycles(NS_OE);
    n_lead = min_cycles(NS_RELEASE);
    n_data = 1;
    while (n_data * CLK_PERIOD < NS_SETUP ||
           (n_lead + n_data) * CLK_PERIOD < NS_PULSE ||
           (n_lead + n_data) * CLK_PERIOD < NS_ADDR_END ||
           (n_lead + n_data + 1) * CLK_PERIOD < NS_CYCLE) n_data++;

    repeat (3) step();               // R1 while in reset
    rst = 1'b0;
    step();                          // R1 first cycle out of reset
    idle_tag = "R2";
    repeat (3) step();               // R2 idle parking

    transfer(1, 18'h00000, 8'hA5, 0, 0);
    transfer(0, 18'h00000, 8'h00, 0, 0);
    transfer(1, 18'h3FFFF, 8'h5A, 0, 0);
    transfer(0, 18'h3FFFF, 8'h00, 0, 0);
    transfer(0, 18'h12345, 8'h00, 0, 0);   // never written
    transfer(0, 18'h3FFFF, 8'h00, 0, 0);   // read then write: R6 turnaround
    transfer(1, 18'h00001, 8'hC3, 1, 0);   // R9 scrambled inputs
    transfer(0, 18'h00001, 8'h00, 1, 0);
    transfer(1, 18'h00002, 8'h7E, 0, 1);   // R8 request held through ack
    transfer(0, 18'h00002, 8'h00, 0, 1);
    for (int i = 0; i < 40; i++)
      transfer((i % 3) != 2, AW'((i % 8) * 4099), 8'(i * 37 + 5), i[0], i[1]);
    repeat (4) step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule